// File: doc/BRIEF.md
# Dual-Threshold Watchdog Timer

This block is a watchdog built on a single up-counter that runs on the peripheral clock. Two separate timeouts watch the same counter. The first is an early-warning interrupt, which gives software one last chance to recover. The second is a later one-cycle reset request that goes to the system reset controller. Each timeout is chosen by a small select field. The field picks a period of 2^(TOP_BIT − field) cycles, so raising the field by one halves the period. With the default parameters, field 15 selects 2^16 cycles and field 0 selects 2^31 cycles.

Software feeds the watchdog with a one-cycle strobe. The feed zeroes the counter, which restarts both timeouts, and it also clears a pending interrupt. When the watchdog is disabled, the counter is held at zero.

A reset request also sets a sticky cause flag. The system reset (`rstN`) does not clear this flag. Only the power-on reset (`porRstN`) or an explicit clear strobe clears it. After any reset, software can read the flag to tell a watchdog reset from other resets.

Top module: `dual_wdt`

## Requirements
- R1: While `rstN` is low, `intIrq` and `rstReq` are 0. While `porRstN` is low, `causeFlag` is 0.
- R2: Let E = TOP_BIT − `intSel`, with `wdEn`=1, `intEn`=1 and no other event. `intIrq` goes high right after the 2^E-th rising edge that follows the edge at which a feed was sampled.
- R3: Let R = TOP_BIT − `rstSel`, with `wdEn`=1 and `rstEn`=1. `rstReq` is high for exactly one cycle, right after the 2^R-th edge that follows a feed. The counter then restarts from zero, so the next request comes 2^R cycles later.
- R4: `intIrq` stays high until a clearing event. A clearing event is a sampled `intClr`, a sampled `feed`, or a reset request. If `intClr` arrives in the same cycle as a new interrupt timeout, the interrupt is set.
- R5: When `intEn` is low, `intIrq` never rises. When `rstEn` is low, `rstReq` never asserts and `causeFlag` is not set.
- R6: When the reset period is shorter than or equal to the interrupt period, the reset request comes with no interrupt before it or at the same time.
- R7: A sampled `feed` zeroes the counter, so both timeouts start over from the feed.
- R8: While `wdEn` is low, the counter stays at zero and no timeout occurs. The edge at which `wdEn` is first sampled high counts as the first counted cycle, so `intIrq` rises right after the 2^E-th enabled edge.
- R9: A reset request sets `causeFlag`, and the flag is already high in the cycle in which `rstReq` is high. The flag keeps its value through `rstN`. Only a sampled `causeClr` or `porRstN` low clears it. If `causeClr` coincides with a new reset request, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | System reset, active low, asynchronous |
| porRstN | input | 1 | Power-on reset, active low; clears the cause flag |
| wdEn | input | 1 | Counter enable; low holds the counter at zero |
| intEn | input | 1 | Interrupt timeout enable |
| rstEn | input | 1 | Reset timeout enable |
| intSel | input | FIELD_W | Interrupt period select, period 2^(TOP_BIT − intSel) |
| rstSel | input | FIELD_W | Reset period select, period 2^(TOP_BIT − rstSel) |
| feed | input | 1 | Feed strobe; zeroes the counter and clears the interrupt |
| intClr | input | 1 | Interrupt clear strobe |
| causeClr | input | 1 | Cause flag clear strobe |
| intIrq | output | 1 | Sticky early-warning interrupt |
| rstReq | output | 1 | One-cycle reset request |
| causeFlag | output | 1 | Sticky watchdog-reset cause flag |

## Verification
The bench uses a reduced configuration with eight select values. It sweeps every interrupt select with the reset timeout disabled, which checks each power-of-two exponent one by one. It then sweeps every reset select and every interrupt/reset select pair. The pair sweep separates the case where the interrupt comes before the reset from the equal and reversed cases, where the interrupt must be suppressed. Directed sequences then check the enable gating, the sticky clear paths, restart on enable, and survival of the cause flag across the system reset but not across the power-on reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from control to the counter datapath
  typedef struct packed {
    logic clear;
    logic inc;
  } cntStrb_t;

  localparam int N_CHAN   = 2;
  localparam int CH_INT   = 0;
  localparam int CH_RESET = 1;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int TOP_BIT = 31,
  parameter int CNT_W   = TOP_BIT + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrb_t           strb,
  input  logic [FIELD_W-1:0] intSel,
  input  logic [FIELD_W-1:0] rstSel,
  output logic [N_CHAN-1:0]  hit,
  output logic [CNT_W-1:0]   cntVal
);
  localparam int SH_W = $clog2(CNT_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [N_CHAN-1:0][FIELD_W-1:0] selArr;

  assign selArr[CH_INT]   = intSel;
  assign selArr[CH_RESET] = rstSel;
  assign cntVal = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (strb.clear) cnt <= '0;
    else if (strb.inc)   cnt <= cnt + CNT_W'(1);
  end

  // One comparator per timeout: hit on the increment that sets bit (TOP_BIT - sel)
  for (genvar g = 0; g < N_CHAN; g++) begin : gChan
    logic [SH_W-1:0]  expo;
    logic [CNT_W-1:0] target;
    assign expo   = SH_W'(TOP_BIT) - SH_W'(selArr[g]);
    assign target = (CNT_W'(1) << expo) - CNT_W'(1);
    assign hit[g] = strb.inc && (cnt == target);
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cnt == '0)) else $error("counter not cleared"); // R7
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              porRstN,
  input  logic              wdEn,
  input  logic              intEn,
  input  logic              rstEn,
  input  logic              feed,
  input  logic              intClr,
  input  logic              causeClr,
  input  logic [N_CHAN-1:0] hit,
  output cntStrb_t          strb,
  output logic              intIrq,
  output logic              rstReq,
  output logic              causeFlag
);
  logic rstFire;
  logic intSet;
  logic intDrop;

  assign strb.inc   = wdEn && !feed;
  assign rstFire    = hit[CH_RESET] && rstEn;
  assign strb.clear = !wdEn || feed || rstFire;
  // Reset wins over a simultaneous interrupt timeout
  assign intSet     = hit[CH_INT] && intEn && !rstFire;
  assign intDrop    = intClr || feed || rstFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intIrq <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= rstFire;
      if (intSet)       intIrq <= 1'b1;
      else if (intDrop) intIrq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)      causeFlag <= 1'b0;
    else if (rstFire)  causeFlag <= 1'b1;
    else if (causeClr) causeFlag <= 1'b0;
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq) else $error("reset request longer than one cycle"); // R3
  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |=> !$rose(intIrq)) else $error("interrupt rose while disabled"); // R5
  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    intIrq && !intClr && !feed |=> intIrq || rstReq) else $error("interrupt dropped"); // R4
  AST_RST_NO_INT: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> !$rose(intIrq)) else $error("interrupt with reset"); // R6
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rstN || !porRstN)
    rstReq |-> causeFlag) else $error("cause flag missing"); // R9
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    causeFlag && !causeClr |=> causeFlag) else $error("cause flag lost"); // R9
endmodule

// File: rtl/dual_wdt.sv
module dual_wdt
  import wdt_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int TOP_BIT = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               porRstN,
  input  logic               wdEn,
  input  logic               intEn,
  input  logic               rstEn,
  input  logic [FIELD_W-1:0] intSel,
  input  logic [FIELD_W-1:0] rstSel,
  input  logic               feed,
  input  logic               intClr,
  input  logic               causeClr,
  output logic               intIrq,
  output logic               rstReq,
  output logic               causeFlag
);
  localparam int CNT_W = TOP_BIT + 1;

  cntStrb_t          strb;
  logic [N_CHAN-1:0] hit;
  logic [CNT_W-1:0]  cntVal;

  wdt_datapath #(.FIELD_W(FIELD_W), .TOP_BIT(TOP_BIT), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .intSel(intSel), .rstSel(rstSel),
    .hit(hit), .cntVal(cntVal)
  );

  wdt_control uCtl (
    .clk(clk), .rstN(rstN), .porRstN(porRstN), .wdEn(wdEn), .intEn(intEn),
    .rstEn(rstEn), .feed(feed), .intClr(intClr), .causeClr(causeClr),
    .hit(hit), .strb(strb), .intIrq(intIrq), .rstReq(rstReq), .causeFlag(causeFlag)
  );

  initial begin
    AST_SEL_RANGE: assert (TOP_BIT >= (1 << FIELD_W)) else $error("exponent too small"); // R2
  end

  AST_FEED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    feed |=> (cntVal == '0)) else $error("feed did not zero counter"); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !wdEn |=> (cntVal == '0) && !rstReq) else $error("disabled watchdog ran"); // R8
endmodule

// File: tb/dual_wdt_test.sv
module dual_wdt_test;
  localparam int FW  = 3;
  localparam int TOP = 9;
  localparam int NS  = 1 << FW;

  logic clk = 1'b0;
  logic rstN = 1'b0, porRstN = 1'b0;
  logic wdEn = 1'b0, intEn = 1'b0, rstEn = 1'b0;
  logic [FW-1:0] intSel = '0, rstSel = '0;
  logic feed = 1'b0, intClr = 1'b0, causeClr = 1'b0;
  logic intIrq, rstReq, causeFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  dual_wdt #(.FIELD_W(FW), .TOP_BIT(TOP)) uut (
    .clk(clk), .rstN(rstN), .porRstN(porRstN), .wdEn(wdEn), .intEn(intEn),
    .rstEn(rstEn), .intSel(intSel), .rstSel(rstSel), .feed(feed),
    .intClr(intClr), .causeClr(causeClr), .intIrq(intIrq), .rstReq(rstReq),
    .causeFlag(causeFlag)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doFeed();
    @(negedge clk) feed = 1'b1;
    @(negedge clk) feed = 1'b0;
  endtask

  task automatic strobeClr(input bit which);
    @(negedge clk);
    if (which) causeClr = 1'b1; else intClr = 1'b1;
    @(negedge clk) begin causeClr = 1'b0; intClr = 1'b0; end
  endtask

  // Count edges from now; record first interrupt edge and first reset edge
  task automatic runEdges(input int limit, input bit stopOnIrq,
                          output int cI, output int cR);
    cI = 0; cR = 0;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      if (intIrq && cI == 0) cI = c;
      if (rstReq) begin cR = c; break; end
      if (stopOnIrq && cI != 0) break;
    end
  endtask

  initial begin
    #700000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cI, cR, ei, er, w;
    // R1: reset state
    #5;
    @(negedge clk);
    check(!intIrq && !rstReq, "R1 outputs in reset", {intIrq, rstReq}, 0);
    check(!causeFlag, "R1 cause in por", causeFlag, 0);
    @(negedge clk) begin rstN = 1'b1; porRstN = 1'b1; end

    // R2: sweep interrupt select, reset timeout off
    wdEn = 1'b1; intEn = 1'b1; rstEn = 1'b0;
    for (int s = 0; s < NS; s++) begin
      intSel = FW'(s);
      doFeed();
      runEdges(1100, 1'b1, cI, cR);
      check(cI == (1 << (TOP - s)), "R2 interrupt delay", cI, 1 << (TOP - s));
    end

    // R3/R9: sweep reset select, interrupt off
    intEn = 1'b0; rstEn = 1'b1;
    for (int s = 0; s < NS; s++) begin
      rstSel = FW'(s);
      strobeClr(1'b1);
      doFeed();
      runEdges(1100, 1'b0, cI, cR);
      check(cR == (1 << (TOP - s)), "R3 reset delay", cR, 1 << (TOP - s));
      check(causeFlag, "R9 cause set with request", causeFlag, 1);
      @(negedge clk) w = rstReq;
      check(w == 0, "R3 one-cycle pulse", w, 0);
      // counter restarted at the request: next one after 2^R more edges
      runEdges(1100, 1'b0, cI, cR);
      check(cR == (1 << (TOP - s)) - 1, "R3 restart after request", cR, (1 << (TOP - s)) - 1);
    end

    // R5: interrupt gating with intEn low
    intSel = FW'(5); rstEn = 1'b0;
    doFeed();
    runEdges(40, 1'b0, cI, cR);
    check(cI == 0, "R5 no interrupt when disabled", cI, 0);

    // R6: all select pairs with both enabled
    intEn = 1'b1; rstEn = 1'b1;
    for (int i = 0; i < NS; i++) begin
      for (int r = 0; r < NS; r++) begin
        intSel = FW'(i); rstSel = FW'(r);
        ei = TOP - i; er = TOP - r;
        doFeed();
        runEdges(1100, 1'b0, cI, cR);
        check(cR == (1 << er) && cI == ((ei < er) ? (1 << ei) : 0),
              "R6 pair order", cI, (ei < er) ? (1 << ei) : 0);
      end
    end

    // R5: reset gating with rstEn low, cause untouched
    strobeClr(1'b1);
    rstEn = 1'b0; rstSel = FW'(7); intSel = FW'(0);
    doFeed();
    runEdges(40, 1'b0, cI, cR);
    check(cR == 0 && !causeFlag, "R5 no reset when disabled", cR, 0);

    // R4: sticky interrupt, intClr clears it, feed clears it
    intSel = FW'(7);
    doFeed();
    runEdges(10, 1'b1, cI, cR);
    repeat (10) @(negedge clk);
    check(intIrq, "R4 interrupt held", intIrq, 1);
    strobeClr(1'b0);
    check(!intIrq, "R4 intClr clears", intIrq, 0);
    runEdges(1100, 1'b1, cI, cR);
    check(cI != 0, "R4 interrupt again", cI, 1);
    doFeed();
    check(!intIrq, "R4 feed clears", intIrq, 0);

    // R7: periodic feeding before the timeout keeps both quiet
    rstEn = 1'b1; intSel = FW'(6); rstSel = FW'(5);
    doFeed();
    w = 0;
    for (int k = 0; k < 20; k++) begin
      repeat (5) @(negedge clk);
      if (intIrq || rstReq) w = 1;
      doFeed();
    end
    check(w == 0, "R7 feeding restarts timeouts", w, 0);

    // R8: disabled watchdog stays idle, restart from zero on enable
    rstEn = 1'b0;
    @(negedge clk) wdEn = 1'b0;
    runEdges(600, 1'b0, cI, cR);
    check(cI == 0 && cR == 0, "R8 idle while disabled", cI + cR, 0);
    intSel = FW'(4);
    @(negedge clk) wdEn = 1'b1;
    runEdges(1100, 1'b1, cI, cR);
    check(cI == (1 << (TOP - 4)), "R8 enable restart", cI, 1 << (TOP - 4));
    doFeed();

    // R9: cause survives system reset, cleared by clear and by por
    intEn = 1'b0; rstEn = 1'b1; rstSel = FW'(7);
    doFeed();
    runEdges(100, 1'b0, cI, cR);
    rstEn = 1'b0;
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    check(causeFlag, "R9 survives rstN", causeFlag, 1);
    check(!intIrq && !rstReq, "R1 rstN clears outputs", {intIrq, rstReq}, 0);
    strobeClr(1'b1);
    check(!causeFlag, "R9 causeClr clears", causeFlag, 0);
    rstEn = 1'b1;
    doFeed();
    runEdges(100, 1'b0, cI, cR);
    rstEn = 1'b0;
    check(causeFlag, "R9 set again", causeFlag, 1);
    @(negedge clk) porRstN = 1'b0;
    @(negedge clk) porRstN = 1'b1;
    check(!causeFlag, "R1 por clears cause", causeFlag, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule